// File: doc/BRIEF.md
# Receive address filter

This block decides, frame by frame, whether a received Ethernet frame is kept, based on its 48-bit destination address. It compares the address against four exact-match entries, where entry 0 is the station's own address and entries 1 to 3 are extra slots for group addresses. It can also look up a 64-bin multicast hash table using a 6-bit index that is computed upstream from the frame check sequence. A promiscuous mode accepts everything.

Alongside the keep/drop decision, the block produces the filter-result bits that the receive engine writes into the descriptor status word. These bits are broadcast, multicast, hash hit, exact hit and the number of the matching entry. Computing the check sequence, parsing the frame and moving data are done elsewhere. Software sets up the tables and the control bits through a simple 16-bit write port.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset every register is zero: all filter outputs are 0, `res_vld` is 0, promiscuous and hash modes are off, and all entries and hash bins are clear.
- R2: One `addr_vld` cycle produces `res_vld` high for exactly the following cycle, with all results for that address. Between strobes the results hold their last value.
- R3: The control word is at byte offset 0x00. Bit 5 turns on promiscuous mode and bit 8 turns on the multicast hash lookup. A write to any offset that maps to no register changes nothing.
- R4: Exact entry e (0..3) sits at offset 0x20 + 8*e, with its low, middle and high words at +0, +2 and +4. The first byte of the address on the wire is `dest_addr[7:0]`, and it is held in the low byte of the low word.
- R5: An entry that equals the destination address gives an exact hit (status 0x0004). An entry that is all zeros never matches.
- R6: When several entries match, the lowest-numbered one is reported in `res_exact_idx` and in status bits [1:0]. With no exact hit the index is 0.
- R7: The all-ones address sets the broadcast flag (status 0x0020) and is always accepted, whatever the mode.
- R8: An address whose group bit `dest_addr[0]` is 1, other than broadcast, sets the multicast flag (status 0x0010). Broadcast never sets it.
- R9: The hash words sit at offsets 0x10, 0x12, 0x14 and 0x16. `hash_idx[5:4]` picks the word and `hash_idx[3:0]` picks the bit. A hash hit (status 0x0008) needs hash mode on, a multicast address and the selected bit set.
- R10: In promiscuous mode every address is accepted. Promiscuous mode alone sets none of the hit flags.
- R11: `res_accept` is high exactly when promiscuous mode is on, or the address is broadcast, or there is an exact hit, or there is a hash hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 16 | Register write data |
| addr_vld | input | 1 | Destination address and hash index are valid this cycle |
| dest_addr | input | 48 | Destination address, first byte on the wire in [7:0] |
| hash_idx | input | 6 | Hash bin index for this frame |
| res_vld | output | 1 | Results below belong to the previous strobe |
| res_accept | output | 1 | Frame is kept |
| res_bcast | output | 1 | Broadcast address |
| res_mcast | output | 1 | Non-broadcast group address |
| res_hash_hit | output | 1 | Hash table hit |
| res_exact_hit | output | 1 | Exact table hit |
| res_exact_idx | output | 2 | Lowest matching entry |
| res_status | output | 16 | Status bits in descriptor layout |

## Verification
Each result is due on the first clock edge after the `addr_vld` cycle. A register write takes effect on the edge after its `cfg_we` cycle. The bench therefore drives inputs on a falling edge, drops the strobe on the next falling edge, and samples all results at that moment, which is one register stage after the stimulus. One falling edge later it checks that `res_vld` has dropped and that the results have held. Writes always finish a full cycle before the next strobe, so a result never depends on a write made in the same cycle.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

  // register byte offsets
  localparam int OFS_CTRL     = 'h00;
  localparam int OFS_HASH     = 'h10;
  localparam int OFS_ENTRY    = 'h20;
  localparam int ENTRY_STRIDE = 8;

  // control word bit positions
  localparam int CTRL_PROMISC_BIT = 5;
  localparam int CTRL_HASH_BIT    = 8;

  // descriptor status bit positions
  localparam int ST_BCAST_BIT = 5;
  localparam int ST_MCAST_BIT = 4;
  localparam int ST_HASH_BIT  = 3;
  localparam int ST_EXACT_BIT = 2;

  typedef struct packed {
    logic accept;
    logic bcast;
    logic mcast;
    logic hash_hit;
    logic exact_hit;
  } flt_res_t;

endpackage

// File: rtl/rxaf_rst_sync.sv
module rxaf_rst_sync (
  input  logic clk,
  input  logic rst_an,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_an) begin
    if (!rst_an) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/rxaf_regs.sv
module rxaf_regs
  import rxaf_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  parameter int ADDR_W    = 48,
  parameter int WORD_W    = 16,
  parameter int HASH_BITS = 64,
  parameter int REG_AW    = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [REG_AW-1:0]                 wr_addr,
  input  logic [WORD_W-1:0]                 wr_data,
  output logic                              promisc_o,
  output logic                              hash_en_o,
  output logic [N_ENTRIES-1:0][ADDR_W-1:0]  entries_o,
  output logic [HASH_BITS-1:0]              hash_tbl_o
);
  localparam int WPA        = ADDR_W / WORD_W;
  localparam int HASH_WORDS = HASH_BITS / WORD_W;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int N_EWORDS   = N_ENTRIES * WPA;

  logic                promisc_q, promisc_d;
  logic                hash_en_q, hash_en_d;
  logic [WORD_W-1:0]   ent_q  [N_EWORDS];
  logic [WORD_W-1:0]   ent_d  [N_EWORDS];
  logic [WORD_W-1:0]   hash_q [HASH_WORDS];
  logic [WORD_W-1:0]   hash_d [HASH_WORDS];

  // next state
  always_comb begin
    promisc_d = promisc_q;
    hash_en_d = hash_en_q;
    if (wr_en && int'(wr_addr) == OFS_CTRL) begin
      promisc_d = wr_data[CTRL_PROMISC_BIT];
      hash_en_d = wr_data[CTRL_HASH_BIT];
    end
  end

  always_comb begin
    for (int e = 0; e < N_ENTRIES; e++) begin
      for (int w = 0; w < WPA; w++) begin
        ent_d[e*WPA+w] = ent_q[e*WPA+w];
        if (wr_en && int'(wr_addr) == OFS_ENTRY + e*ENTRY_STRIDE + w*WORD_BYTES)
          ent_d[e*WPA+w] = wr_data;
      end
    end
  end

  always_comb begin
    for (int j = 0; j < HASH_WORDS; j++) begin
      hash_d[j] = hash_q[j];
      if (wr_en && int'(wr_addr) == OFS_HASH + j*WORD_BYTES)
        hash_d[j] = wr_data;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      promisc_q <= 1'b0;
      hash_en_q <= 1'b0;
    end else if (wr_en) begin
      promisc_q <= promisc_d;
      hash_en_q <= hash_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_EWORDS; i++) ent_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < N_EWORDS; i++) ent_q[i] <= ent_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < HASH_WORDS; j++) hash_q[j] <= '0;
    end else if (wr_en) begin
      for (int j = 0; j < HASH_WORDS; j++) hash_q[j] <= hash_d[j];
    end
  end

  // outputs
  assign promisc_o = promisc_q;
  assign hash_en_o = hash_en_q;

  always_comb begin
    for (int e = 0; e < N_ENTRIES; e++)
      for (int w = 0; w < WPA; w++)
        entries_o[e][w*WORD_W +: WORD_W] = ent_q[e*WPA+w];
  end

  always_comb begin
    for (int j = 0; j < HASH_WORDS; j++)
      hash_tbl_o[j*WORD_W +: WORD_W] = hash_q[j];
  end

  // a write to the control word must land in the mode bits
  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) == OFS_CTRL) |=>
      (promisc_o == $past(wr_data[CTRL_PROMISC_BIT]) &&
       hash_en_o == $past(wr_data[CTRL_HASH_BIT]))); // R3

  // writes that hit no register leave the mode bits alone
  AST_CTRL_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && int'(wr_addr) == OFS_CTRL)) |=>
      ($stable(promisc_o) && $stable(hash_en_o))); // R3
endmodule

// File: rtl/rxaf_exact.sv
module rxaf_exact #(
  parameter int N_ENTRIES = 4,
  parameter int ADDR_W    = 48,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [N_ENTRIES-1:0][ADDR_W-1:0]  entries_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  output logic                              hit_o,
  output logic [IDX_W-1:0]                  idx_o
);
  logic [N_ENTRIES-1:0] match;

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_cmp
    assign match[e] = (entries_i[e] != '0) && (entries_i[e] == addr_i);
  end

  // lowest matching entry wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int e = N_ENTRIES-1; e >= 0; e--) begin
      if (match[e]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(e);
      end
    end
  end

  AST_EXACT_IDX_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> match[idx_o]); // R5

  AST_EXACT_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> ((match & ~({N_ENTRIES{1'b1}} << idx_o)) == '0)); // R6
endmodule

// File: rtl/rxaf_hash.sv
module rxaf_hash #(
  parameter int HASH_IDX_W = 6,
  parameter int WORD_W     = 16,
  localparam int HASH_BITS  = 1 << HASH_IDX_W,
  localparam int HASH_WORDS = HASH_BITS / WORD_W,
  localparam int BIT_W      = $clog2(WORD_W)
) (
  input  logic [HASH_BITS-1:0]  tbl_i,
  input  logic [HASH_IDX_W-1:0] idx_i,
  output logic                  bit_o
);
  logic [HASH_WORDS-1:0]        word_bit;
  logic [BIT_W-1:0]             bit_sel;
  logic [HASH_IDX_W-BIT_W-1:0]  word_sel;

  assign bit_sel  = idx_i[BIT_W-1:0];
  assign word_sel = idx_i[HASH_IDX_W-1:BIT_W];

  for (genvar j = 0; j < HASH_WORDS; j++) begin : g_word
    logic [WORD_W-1:0] word;
    assign word        = tbl_i[j*WORD_W +: WORD_W];
    assign word_bit[j] = word[bit_sel];
  end

  assign bit_o = word_bit[word_sel];
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxaf_pkg::*;
#(
  parameter int N_ENTRIES  = 4,
  parameter int ADDR_W     = 48,
  parameter int WORD_W     = 16,
  parameter int HASH_IDX_W = 6,
  parameter int REG_AW     = 8,
  localparam int IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int HASH_BITS = 1 << HASH_IDX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [REG_AW-1:0]     cfg_addr,
  input  logic [WORD_W-1:0]     cfg_wdata,
  input  logic                  addr_vld,
  input  logic [ADDR_W-1:0]     dest_addr,
  input  logic [HASH_IDX_W-1:0] hash_idx,
  output logic                  res_vld,
  output logic                  res_accept,
  output logic                  res_bcast,
  output logic                  res_mcast,
  output logic                  res_hash_hit,
  output logic                  res_exact_hit,
  output logic [IDX_W-1:0]      res_exact_idx,
  output logic [15:0]           res_status
);
  logic                             rst_s;
  logic                             promisc, hash_en;
  logic [N_ENTRIES-1:0][ADDR_W-1:0] entries;
  logic [HASH_BITS-1:0]             hash_tbl;
  logic                             ex_hit;
  logic [IDX_W-1:0]                 ex_idx;
  logic                             bin_set;

  rxaf_rst_sync u_rst (
    .clk    (clk),
    .rst_an (rst_n),
    .rst_sn (rst_s)
  );

  rxaf_regs #(
    .N_ENTRIES (N_ENTRIES),
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .HASH_BITS (HASH_BITS),
    .REG_AW    (REG_AW)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_s),
    .wr_en      (cfg_we),
    .wr_addr    (cfg_addr),
    .wr_data    (cfg_wdata),
    .promisc_o  (promisc),
    .hash_en_o  (hash_en),
    .entries_o  (entries),
    .hash_tbl_o (hash_tbl)
  );

  rxaf_exact #(
    .N_ENTRIES (N_ENTRIES),
    .ADDR_W    (ADDR_W)
  ) u_exact (
    .clk       (clk),
    .rst_n     (rst_s),
    .entries_i (entries),
    .addr_i    (dest_addr),
    .hit_o     (ex_hit),
    .idx_o     (ex_idx)
  );

  rxaf_hash #(
    .HASH_IDX_W (HASH_IDX_W),
    .WORD_W     (WORD_W)
  ) u_hash (
    .tbl_i (hash_tbl),
    .idx_i (hash_idx),
    .bit_o (bin_set)
  );

  // classification
  flt_res_t         cls;
  flt_res_t         res_q, res_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             vld_q;

  always_comb begin
    cls.bcast     = &dest_addr;
    cls.mcast     = dest_addr[0] && !cls.bcast;
    cls.hash_hit  = hash_en && cls.mcast && bin_set;
    cls.exact_hit = ex_hit;
    cls.accept    = promisc || cls.bcast || cls.exact_hit || cls.hash_hit;
  end

  // next state
  always_comb begin
    res_d = res_q;
    idx_d = idx_q;
    if (addr_vld) begin
      res_d = cls;
      idx_d = ex_hit ? ex_idx : '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      res_q <= '0;
      idx_q <= '0;
    end else if (addr_vld) begin
      res_q <= res_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) vld_q <= 1'b0;
    else        vld_q <= addr_vld;
  end

  // outputs
  assign res_vld       = vld_q;
  assign res_accept    = res_q.accept;
  assign res_bcast     = res_q.bcast;
  assign res_mcast     = res_q.mcast;
  assign res_hash_hit  = res_q.hash_hit;
  assign res_exact_hit = res_q.exact_hit;
  assign res_exact_idx = idx_q;

  always_comb begin
    res_status               = '0;
    res_status[ST_BCAST_BIT] = res_q.bcast;
    res_status[ST_MCAST_BIT] = res_q.mcast;
    res_status[ST_HASH_BIT]  = res_q.hash_hit;
    res_status[ST_EXACT_BIT] = res_q.exact_hit;
    res_status[IDX_W-1:0]    = idx_q;
  end

  // assertions
  AST_RES_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_s)
    addr_vld |=> res_vld); // R2

  AST_RES_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_s)
    !addr_vld |=> !res_vld); // R2

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_s)
    !addr_vld |=> ($stable(res_status) && $stable(res_accept))); // R2

  AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (!rst_s)
    (addr_vld && promisc) |=> res_accept); // R10

  AST_BCAST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_s)
    (addr_vld && (&dest_addr)) |=> (res_accept && res_bcast)); // R7

  AST_BCAST_NOT_MCAST: assert property (@(posedge clk) disable iff (!rst_s)
    res_bcast |-> !res_mcast); // R8

  AST_IDX_ZERO_NO_HIT: assert property (@(posedge clk) disable iff (!rst_s)
    !res_exact_hit |-> (res_exact_idx == '0)); // R6

  AST_HASH_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_s)
    (addr_vld && !hash_en) |=> !res_hash_hit); // R9

  AST_ACCEPT_REASON: assert property (@(posedge clk) disable iff (!rst_s)
    (addr_vld && !promisc) |=>
      (res_accept == (res_bcast || res_exact_hit || res_hash_hit))); // R11
endmodule

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        addr_vld;
  logic [47:0] dest_addr;
  logic [5:0]  hash_idx;
  logic        res_vld, res_accept, res_bcast, res_mcast;
  logic        res_hash_hit, res_exact_hit;
  logic [1:0]  res_exact_idx;
  logic [15:0] res_status;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  // addresses: first wire byte in [7:0]
  localparam logic [47:0] STA  = 48'h5544_3322_1102; // 02:11:22:33:44:55
  localparam logic [47:0] UNI  = 48'hEEDD_CCBB_AA02; // 02:aa:bb:cc:dd:ee
  localparam logic [47:0] GRPX = 48'h0100_005E_0001; // 01:00:5e:00:00:01
  localparam logic [47:0] GRPY = 48'h0900_7F5E_0001; // 01:00:5e:7f:00:09
  localparam logic [47:0] BCST = 48'hFFFF_FFFF_FFFF;

  always #10 clk = ~clk; // 50 MHz

  rx_addr_filter dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_addr      (cfg_addr),
    .cfg_wdata     (cfg_wdata),
    .addr_vld      (addr_vld),
    .dest_addr     (dest_addr),
    .hash_idx      (hash_idx),
    .res_vld       (res_vld),
    .res_accept    (res_accept),
    .res_bcast     (res_bcast),
    .res_mcast     (res_mcast),
    .res_hash_hit  (res_hash_hit),
    .res_exact_hit (res_exact_hit),
    .res_exact_idx (res_exact_idx),
    .res_status    (res_status)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // R4: entry e at 0x20+8e, words low/mid/high at +0/+2/+4
  task automatic set_entry(int e, logic [47:0] a);
    reg_wr(8'(32 + 8*e),     a[15:0]);
    reg_wr(8'(32 + 8*e + 2), a[31:16]);
    reg_wr(8'(32 + 8*e + 4), a[47:32]);
  endtask

  // drive one strobe, check results one cycle later
  task automatic probe(string tag, logic [47:0] a, logic [5:0] h,
                       logic exp_acc, logic [15:0] exp_st);
    @(negedge clk);
    addr_vld = 1'b1; dest_addr = a; hash_idx = h;
    @(negedge clk);
    addr_vld = 1'b0;
    check({tag, " R2 vld"}, 16'(res_vld), 16'h1);
    check({tag, " R11 accept"}, 16'(res_accept), 16'(exp_acc));
    check({tag, " status"}, res_status, exp_st);
    check({tag, " flags"},
          {9'b0, res_bcast, res_mcast, res_hash_hit, res_exact_hit, 1'b0, res_exact_idx},
          {9'b0, exp_st[5:2], 1'b0, exp_st[1:0]});
  endtask

  task automatic t_reset();
    check("R1 vld", 16'(res_vld), 16'h0);
    check("R1 accept", 16'(res_accept), 16'h0);
    check("R1 status", res_status, 16'h0);
    probe("R1 tables clear", UNI, 6'h00, 1'b0, 16'h0000);
  endtask

  task automatic t_zero_entry();
    probe("R5 zero entry never matches", 48'h0, 6'h00, 1'b0, 16'h0000);
  endtask

  task automatic t_station();
    set_entry(0, STA);
    probe("R4 R5 station hit", STA, 6'h00, 1'b1, 16'h0004);
    probe("R5 other unicast", UNI, 6'h00, 1'b0, 16'h0000);
  endtask

  task automatic t_hold();
    probe("R2 hold base", STA, 6'h11, 1'b1, 16'h0004);
    @(negedge clk);
    check("R2 vld drops", 16'(res_vld), 16'h0);
    check("R2 status held", res_status, 16'h0004);
    check("R2 accept held", 16'(res_accept), 16'h1);
  endtask

  task automatic t_priority();
    set_entry(3, GRPX);
    probe("R6 entry3", GRPX, 6'h00, 1'b1, 16'h0017);
    set_entry(2, GRPX);
    probe("R6 lowest of 2,3", GRPX, 6'h00, 1'b1, 16'h0016);
    set_entry(2, 48'h0);
    probe("R6 cleared slot", GRPX, 6'h00, 1'b1, 16'h0017);
  endtask

  task automatic t_unmapped();
    reg_wr(8'h02, 16'hFFFF);
    reg_wr(8'h06, 16'hFFFF);
    reg_wr(8'h1E, 16'hFFFF);
    reg_wr(8'h26, 16'hFFFF);
    probe("R3 unmapped no promisc", UNI, 6'h3F, 1'b0, 16'h0000);
    probe("R3 unmapped entry kept", STA, 6'h00, 1'b1, 16'h0004);
  endtask

  task automatic t_bcast();
    probe("R7 R8 broadcast", BCST, 6'h00, 1'b1, 16'h0020);
  endtask

  task automatic t_hash();
    reg_wr(8'h14, 16'h0020); // word 2, bit 5 -> index 0x25
    probe("R9 hash off", GRPY, 6'h25, 1'b0, 16'h0010);
    reg_wr(8'h00, 16'h0100);
    probe("R9 hash hit", GRPY, 6'h25, 1'b1, 16'h0018);
    probe("R9 bit clear", GRPY, 6'h24, 1'b0, 16'h0010);
    probe("R9 other word", GRPY, 6'h05, 1'b0, 16'h0010);
    probe("R9 unicast no hash", UNI, 6'h25, 1'b0, 16'h0000);
  endtask

  task automatic t_promisc();
    reg_wr(8'h00, 16'h0020);
    probe("R10 unicast", UNI, 6'h00, 1'b1, 16'h0000);
    probe("R10 group no hash", GRPY, 6'h25, 1'b1, 16'h0010);
    reg_wr(8'h00, 16'h0120);
    probe("R10 R9 both", GRPY, 6'h25, 1'b1, 16'h0018);
    reg_wr(8'h00, 16'h0000);
    probe("R3 modes off", UNI, 6'h25, 1'b0, 16'h0000);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    addr_vld = 1'b0; dest_addr = '0; hash_idx = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_zero_entry();
    t_station();
    t_hold();
    t_priority();
    t_unmapped();
    t_bcast();
    t_hash();
    t_promisc();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule